// File: doc/BRIEF.md
# One-Wire Search Triplet Sequencer

This block performs one step of the ROM search on a one-wire bus as a single command. A start strobe, together with a preferred branch bit, makes it run up to three single-bit slots through a bit-transfer interface. It reads the identifier bit, reads the complement bit, chooses a branch and then transmits that branch bit. When the step ends it pulses `done` and presents a 3-bit code. The bit-level slot timing sits in a separate bit engine. Software runs the 64-step search loop and issues one command for each bit position.

The bit engine is driven through a request that stays high until the engine reports completion or timeout. A read/write flag, the bit to transmit and the received bit go with the request. The request always drops for at least one cycle between two slots. This lets the completion indication of one slot clear before the next slot begins.

Top module: `ow_triplet`

## Requirements
- R1: After reset `busy`, `done`, `err`, `slot_req` are 0 and `result` is 3'b000.
- R2: A command runs the slots in a fixed order: a read slot (`slot_rd`=1) for the identifier bit, a read slot for the complement bit, then a write slot (`slot_rd`=0) that transmits the chosen branch on `slot_wbit`.
- R3: When the identifier and complement bits both read 1, no device answered. `result` is 3'b011, `err` is 0 and no write slot is issued.
- R4: When both bits read 0, the branch is the preferred bit sampled at the start strobe. `result` is 3'b100 for preference 1 and 3'b000 for preference 0, and the same bit is transmitted.
- R5: When exactly one of the two bits reads 1, the branch equals the identifier bit. `result` is 3'b101 when the identifier bit is 1 and 3'b010 when it is 0, and the identifier bit is transmitted.
- R6: `slot_req` stays high until `slot_done` or `slot_tmo` is seen. It is low in the following cycle and stays low for at least one cycle before the next slot begins.
- R7: `result` bit 0 holds the identifier bit, bit 1 the complement bit and bit 2 the branch taken. It keeps its value from one completed command until the next completes.
- R8: A `slot_tmo` in any slot ends the command with no further slots. `result` becomes 3'b011 and `err` is high in the same cycle as `done`.
- R9: A start strobe while `busy` is high is ignored, and the preference given with it does not change the running command.
- R10: `done` is high for exactly one cycle per command, and `busy` is low from the cycle after.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe |
| pref_dir | input | 1 | Preferred branch on a discrepancy |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Slot timeout, valid with done |
| result | output | 3 | {branch, complement, identifier} |
| slot_req | output | 1 | Bit slot request to the bit engine |
| slot_rd | output | 1 | 1 = read slot, 0 = write slot |
| slot_wbit | output | 1 | Bit to transmit in a write slot |
| slot_rbit | input | 1 | Bit received in a read slot |
| slot_done | input | 1 | Slot completed |
| slot_tmo | input | 1 | Slot timed out |

## Verification
Two events can land on the same cycle. A fresh start strobe can arrive while a command is still running. A slot's completion can also coincide with the one-cycle gap the sequencer inserts before the next slot. The bench pulses start a few cycles into a discrepancy command with the opposite preference. It then judges by the transmitted bit, the slot count and `result` that the first preference was kept. A bit-engine model that answers in as little as zero wait cycles is used to check that each completion is taken exactly once and produces exactly one slot.

// File: rtl/ow_triplet.sv
module ow_triplet (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       pref_dir,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [2:0] result,
  output logic       slot_req,
  output logic       slot_rd,
  output logic       slot_wbit,
  input  logic       slot_rbit,
  input  logic       slot_done,
  input  logic       slot_tmo
);

  typedef enum logic [1:0] {ST_IDLE, ST_ID, ST_CMP, ST_DIR} st_t;
  localparam logic [2:0] NO_ANSWER = 3'b011;

  st_t        st;
  logic       req_q, id_q, cmp_q, dir_q, pref_q, done_q, err_q;
  logic [2:0] res_q;

  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign result    = res_q;
  assign slot_req  = req_q;
  assign slot_rd   = (st != ST_DIR);
  assign slot_wbit = dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      req_q  <= 1'b0;
      id_q   <= 1'b0;
      cmp_q  <= 1'b0;
      dir_q  <= 1'b0;
      pref_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      res_q  <= 3'b000;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (st == ST_IDLE) begin
        if (start) begin
          pref_q <= pref_dir;
          st     <= ST_ID;
          req_q  <= 1'b0;
        end
      end else if (!req_q) begin
        req_q <= 1'b1;
      end else if (slot_tmo) begin
        req_q  <= 1'b0;
        st     <= ST_IDLE;
        res_q  <= NO_ANSWER;
        err_q  <= 1'b1;
        done_q <= 1'b1;
      end else if (slot_done) begin
        req_q <= 1'b0;
        case (st)
          ST_ID: begin
            id_q <= slot_rbit;
            st   <= ST_CMP;
          end
          ST_CMP: begin
            if (id_q && slot_rbit) begin
              res_q  <= NO_ANSWER;
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              cmp_q <= slot_rbit;
              dir_q <= (id_q ^ slot_rbit) ? id_q : pref_q;
              st    <= ST_DIR;
            end
          end
          ST_DIR: begin
            res_q  <= {dir_q, cmp_q, id_q};
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !busy && !done && !slot_req); // R1
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req && (slot_done || slot_tmo) |=> !slot_req); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req && !slot_done && !slot_tmo |=> slot_req); // R6
  AST_TMO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req && slot_tmo |=> done && err && result == 3'b011 && !busy); // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) err |-> done); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !slot_req); // R10
  AST_WBIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req && !slot_rd |=> !slot_req || $stable(slot_wbit)); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R7

endmodule

// File: tb/ow_triplet_test.sv
`timescale 1ns/1ps
module ow_triplet_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pref_dir = 1'b0;
  logic busy, done, err, slot_req, slot_rd, slot_wbit;
  logic [2:0] result;
  logic slot_rbit = 1'b0, slot_done = 1'b0, slot_tmo = 1'b0;

  always #2.5 clk = ~clk;

  ow_triplet uut (.clk(clk), .rst_n(rst_n), .start(start), .pref_dir(pref_dir),
    .busy(busy), .done(done), .err(err), .result(result), .slot_req(slot_req),
    .slot_rd(slot_rd), .slot_wbit(slot_wbit), .slot_rbit(slot_rbit),
    .slot_done(slot_done), .slot_tmo(slot_tmo));

  // bit engine model
  logic       clr = 1'b0;
  logic [1:0] rbits = 2'b00;   // [0] identifier, [1] complement
  logic [1:0] tmo_at = 2'd3;   // 3 = never
  int         lat = 0;
  int         cnt = 0, slots = 0, writes = 0, order_bad = 0;
  logic       wbit_seen = 1'b0;

  always @(posedge clk) begin
    slot_done <= 1'b0;
    slot_tmo  <= 1'b0;
    if (clr) begin
      cnt <= 0; slots <= 0; writes <= 0; order_bad <= 0; wbit_seen <= 1'b0;
    end else if (slot_req && !slot_done && !slot_tmo) begin
      if (cnt == lat) begin
        cnt <= 0;
        if ((slots < 2) != slot_rd) order_bad <= order_bad + 1;
        if (slots == int'(tmo_at)) slot_tmo <= 1'b1;
        else slot_done <= 1'b1;
        slot_rbit <= (slots < 2) ? rbits[slots] : 1'b0;
        if (!slot_rd) begin
          writes <= writes + 1;
          wbit_seen <= slot_wbit;
        end
        slots <= slots + 1;
      end else cnt <= cnt + 1;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // [10:9] timeout slot, [8] pref, [7] cmp, [6] id, [5:3] result, [2] err, [1:0] slots
  localparam logic [10:0] VEC [8] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 2'd3},
    {2'd3, 1'b1, 1'b0, 1'b0, 3'b100, 1'b0, 2'd3},
    {2'd3, 1'b0, 1'b0, 1'b1, 3'b101, 1'b0, 2'd3},
    {2'd3, 1'b1, 1'b1, 1'b0, 3'b010, 1'b0, 2'd3},
    {2'd3, 1'b0, 1'b1, 1'b1, 3'b011, 1'b0, 2'd2},
    {2'd0, 1'b1, 1'b0, 1'b0, 3'b011, 1'b1, 2'd1},
    {2'd1, 1'b0, 1'b0, 1'b1, 3'b011, 1'b1, 2'd2},
    {2'd2, 1'b1, 1'b0, 1'b0, 3'b011, 1'b1, 2'd3}
  };

  bit timed_out = 1'b0;

  task automatic launch(input logic p, input logic [1:0] bits, input logic [1:0] t);
    @(negedge clk);
    rbits = bits; tmo_at = t; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0; start = 1'b1; pref_dir = p;
    @(negedge clk);
    start = 1'b0; pref_dir = 1'b0;
  endtask

  task automatic wait_done(output logic e, output logic [2:0] r);
    e = 1'b0; r = 3'b000;
    for (int i = 0; i < 300; i++) begin
      if (done) begin
        e = err; r = result;
        break;
      end
      if (i == 299) begin
        timed_out = 1'b1;
        check("R10 done never seen", 0, 1);
      end
      @(negedge clk);
    end
    @(negedge clk);
    check("R10 done one cycle", int'(done), 0);
    check("R10 busy low", int'(busy), 0);
  endtask

  initial begin
    logic e;
    logic [2:0] r;
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 err", int'(err), 0);
    check("R1 req", int'(slot_req), 0);
    check("R1 result", int'(result), 0);
    rst_n = 1'b1;

    foreach (VEC[k]) begin
      lat = k % 4;
      launch(VEC[k][8], VEC[k][7:6], VEC[k][10:9]);
      wait_done(e, r);
      check("R7 result code", int'(r), int'(VEC[k][5:3]));   // R3 R4 R5 R8
      check("R8 err flag", int'(e), int'(VEC[k][2]));
      check("R2 slot count", slots, int'(VEC[k][1:0]));
      check("R2 slot order", order_bad, 0);
      check("R3 write slots", writes, (VEC[k][1:0] == 2'd3) ? 1 : 0);
      if (VEC[k][1:0] == 2'd3 && !VEC[k][2])
        check("R4 R5 transmitted bit", int'(wbit_seen), int'(VEC[k][5]));
    end

    // R9: second strobe with opposite preference during a discrepancy step
    lat = 2;
    launch(1'b0, 2'b00, 2'd3);
    @(negedge clk); start = 1'b1; pref_dir = 1'b1;
    @(negedge clk); start = 1'b0; pref_dir = 1'b0;
    wait_done(e, r);
    check("R9 result kept", int'(r), 0);
    check("R9 transmitted kept", int'(wbit_seen), 0);
    check("R9 single command slots", slots, 3);

    // R7: result holds while idle
    repeat (10) @(negedge clk);
    check("R7 result holds", int'(result), 0);
    check("R10 no stray done", int'(done), 0);
    check("R6 no stray slot", slots, 3);

    // R6: zero-latency engine, completion coincides with the gap
    lat = 0;
    launch(1'b1, 2'b10, 2'd3);
    wait_done(e, r);
    check("R6 zero wait result", int'(r), 3'b010);
    check("R6 zero wait slots", slots, 3);
    check("R6 zero wait bit", int'(wbit_seen), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule